// File: doc/BRIEF.md
# Pending-Event Hit Map Buffer

This block sits between the trigger-side logic that captures a channel hit map for every accepted trigger and the sequencer that digitizes the stored charge and time samples. It keeps up to four pending events, so new triggers can be recorded while an earlier event is still being digitized. Each pending event has an analog storage slot index. The index advances 0, 1, 2, 3 and then wraps, and it travels with the hit map. While all four slots are occupied, the block raises busy so that the trigger source holds off, and a trigger that arrives then is dropped rather than overwriting a slot.

A programmable holdoff window opens after every accepted trigger, and triggers inside the window are refused. This keeps two beam bursts that arrive one after the other from both triggering, at any clock period in the working range. Dropped triggers are counted in a saturating counter.

Hit maps go toward the digitizer, and digitized words come back, over one shared bus that is modelled as a muxed data path with a direction flag. The block arbitrates that bus. Hit maps win when no readout burst is open. An open burst keeps the bus until its last word. The bus always idles for one cycle before it reverses direction.

Top module: `event_map_buffer`

## Requirements
- R1: After reset, busy_o is 0, rej_count_o is 0, and bus_valid_o stays 0 until a trigger is accepted or a readout word is requested.
- R2: An accepted trigger in cycle t loads the holdoff length H from holdoff_i. Triggers in cycles t+1 to t+H are refused, and a trigger in cycle t+H+1 can be accepted. With H=0 there is no holdoff.
- R3: At most DEPTH (default 4) events are held. busy_o is 1 exactly while all DEPTH slots are occupied, and a trigger that arrives while busy_o is 1 is refused, so no slot is ever overwritten.
- R4: Every refused trigger, whether refused for busy or for holdoff, increments rej_count_o. The counter saturates at all ones, and cycles without a trigger leave it unchanged.
- R5: Each accepted hit map is sent once over the bus with bus_dir_o=0 and bus_data_o equal to the map. The maps go out in arrival order, the earliest in the cycle after acceptance. bus_tag_o carries the slot index, which is the number of previously accepted events modulo DEPTH.
- R6: A pulse on seq_done_i frees the oldest event whose map has been sent, and busy_o falls in the next cycle. If no sent, unfreed event exists, seq_done_i has no effect.
- R7: When a trigger and seq_done_i fall in the same cycle, busy is judged on the occupancy before that cycle's edge. A full buffer refuses the trigger. Otherwise the trigger is accepted and the occupancy is unchanged.
- R8: A readout word is transferred in the cycle where rd_gnt_o is 1. In that cycle the bus shows bus_dir_o=1 and bus_data_o equal to rd_data_i.
- R9: Two transfers in opposite directions are always separated by at least one idle bus cycle.
- R10: A readout burst is open from a granted word with rd_last_i=0 until a granted word with rd_last_i=1. While a burst is open, readout words take the bus. Otherwise a pending hit map wins over a readout request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger pulse, one cycle per trigger |
| trig_map_i | input | MAP_W | Hit map captured with the trigger |
| holdoff_i | input | HOLD_W | Holdoff length in cycles |
| busy_o | output | 1 | All slots occupied, hold off triggers |
| rej_count_o | output | CNT_W | Saturating count of refused triggers |
| seq_done_i | input | 1 | Sequencer finished the oldest sent event |
| rd_req_i | input | 1 | Sequencer has a readout word to return |
| rd_last_i | input | 1 | Current readout word ends its burst |
| rd_data_i | input | MAP_W | Readout word |
| rd_gnt_o | output | 1 | Readout word taken this cycle |
| bus_valid_o | output | 1 | A transfer occupies the bus this cycle |
| bus_dir_o | output | 1 | Bus direction, 0 toward the digitizer, 1 back |
| bus_data_o | output | MAP_W | Bus data: a hit map or a readout word |
| bus_tag_o | output | SLOT_W | Slot index of the hit map on the bus, 0 for readout |

## Verification
Two groups of events can land in the same cycle. The first is a trigger and a slot release. The bench drives trigger and seq_done_i together, once with the buffer full, where the trigger must be refused, and once with three slots taken, where it must be accepted with busy staying low until one more trigger arrives. The second is a hit map and a readout word both wanting the bus. The bench opens a readout burst, lands a trigger inside it, and checks the exact cycles of the grant, the idle gap and the delayed map. It then repeats the contest with no burst open, where the map must win. A sweep over every holdoff length from 0 to 4 against trigger spacings from 1 to 6 checks acceptance by the rule that the spacing must exceed the holdoff.

// File: rtl/ebb_pkg.sv
package ebb_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } bus_dir_e;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_MAP  = 2'd1,
        PICK_RDO  = 2'd2
    } arb_pick_e;

    typedef struct packed {
        logic      go;
        bus_dir_e  dir;
        arb_pick_e pick;
    } arb_decision_t;

    function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/emb_holdoff_gate.sv
module emb_holdoff_gate #(
    parameter int HOLD_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    input  logic              full_i,
    output logic              accept_o,
    output logic [CNT_W-1:0]  rej_count_o
);
    logic [HOLD_W-1:0] hold_cnt_q;
    logic              holding;
    logic              refuse;

    assign holding  = (hold_cnt_q != '0);
    assign accept_o = trig_i && !holding && !full_i;
    assign refuse   = trig_i && !accept_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt_q <= '0;
        end else if (accept_o) begin
            hold_cnt_q <= hold_len_i;
        end else if (holding) begin
            hold_cnt_q <= hold_cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rej_count_o <= '0;
        end else if (refuse && (rej_count_o != '1)) begin
            rej_count_o <= rej_count_o + 1'b1;
        end
    end

    // R2: a non-zero holdoff blocks the very next cycle
    assert_holdoff_R2: assert property (@(posedge clk) disable iff (rst)
        (accept_o && hold_len_i != '0) |=> !accept_o);

    // R4: no trigger, no change in the refused count
    assert_rej_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !trig_i |=> $stable(rej_count_o));

endmodule

// File: rtl/emb_slot_fifo.sv
module emb_slot_fifo #(
    parameter int DEPTH  = 4,
    parameter int MAP_W  = 32,
    parameter int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [MAP_W-1:0]  wr_map_i,
    input  logic              send_i,
    input  logic              retire_i,
    output logic              full_o,
    output logic              send_pending_o,
    output logic [MAP_W-1:0]  send_map_o,
    output logic [SLOT_W-1:0] send_slot_o
);
    import ebb_pkg::*;

    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [MAP_W-1:0]  map_mem [DEPTH];
    logic [SLOT_W-1:0] wr_ptr_q, snd_ptr_q, ret_ptr_q;
    logic [OCC_W-1:0]  occ_q, unsent_q;
    logic              retire_ok;

    assign full_o         = (occ_q == OCC_W'(DEPTH));
    assign send_pending_o = (unsent_q != '0);
    assign retire_ok      = retire_i && (occ_q != unsent_q);
    assign send_map_o     = map_mem[snd_ptr_q];
    assign send_slot_o    = snd_ptr_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                map_mem[i] <= '0;
            end else if (wr_en_i && (wr_ptr_q == SLOT_W'(i))) begin
                map_mem[i] <= wr_map_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q  <= '0;
            snd_ptr_q <= '0;
            ret_ptr_q <= '0;
            occ_q     <= '0;
            unsent_q  <= '0;
        end else begin
            if (wr_en_i) begin
                wr_ptr_q <= SLOT_W'(wrap_inc(32'(wr_ptr_q), DEPTH));
            end
            if (send_i) begin
                snd_ptr_q <= SLOT_W'(wrap_inc(32'(snd_ptr_q), DEPTH));
            end
            if (retire_ok) begin
                ret_ptr_q <= SLOT_W'(wrap_inc(32'(ret_ptr_q), DEPTH));
            end
            occ_q    <= occ_q + OCC_W'(wr_en_i) - OCC_W'(retire_ok);
            unsent_q <= unsent_q + OCC_W'(wr_en_i) - OCC_W'(send_i);
        end
    end

    // R3: a write never lands on a full buffer
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        full_o |-> !wr_en_i);

    // R3: occupancy never exceeds the slot count
    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
        occ_q <= OCC_W'(DEPTH));

    // R5: the arbiter only takes a map that is waiting
    assert_send_has_map_R5: assert property (@(posedge clk) disable iff (rst)
        send_i |-> send_pending_o);

    // R6: the release pointer never passes the send pointer
    assert_retire_after_send_R6: assert property (@(posedge clk) disable iff (rst)
        unsent_q <= occ_q);

endmodule

// File: rtl/emb_bus_arbiter.sv
module emb_bus_arbiter #(
    parameter int MAP_W  = 32,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_req_i,
    input  logic [MAP_W-1:0]  map_i,
    input  logic [SLOT_W-1:0] tag_i,
    input  logic              rd_req_i,
    input  logic              rd_last_i,
    input  logic [MAP_W-1:0]  rd_data_i,
    output logic              map_take_o,
    output logic              rd_gnt_o,
    output logic              bus_valid_o,
    output logic              bus_dir_o,
    output logic [MAP_W-1:0]  bus_data_o,
    output logic [SLOT_W-1:0] bus_tag_o
);
    import ebb_pkg::*;

    bus_dir_e      dir_q;
    logic          used_q;
    logic          burst_q;
    arb_decision_t dec;

    always_comb begin
        dec.pick = PICK_NONE;
        if (burst_q) begin
            if (rd_req_i) dec.pick = PICK_RDO;
        end else if (map_req_i) begin
            dec.pick = PICK_MAP;
        end else if (rd_req_i) begin
            dec.pick = PICK_RDO;
        end
        dec.dir = (dec.pick == PICK_RDO) ? DIR_UP : DIR_DOWN;
        dec.go  = !rst && (dec.pick != PICK_NONE) && ((dec.dir == dir_q) || !used_q);
    end

    assign map_take_o  = dec.go && (dec.pick == PICK_MAP);
    assign rd_gnt_o    = dec.go && (dec.pick == PICK_RDO);
    assign bus_valid_o = dec.go;
    assign bus_dir_o   = dec.go ? logic'(dec.dir) : logic'(dir_q);
    assign bus_data_o  = rd_gnt_o ? rd_data_i : (map_take_o ? map_i : '0);
    assign bus_tag_o   = map_take_o ? tag_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= DIR_DOWN;
            used_q  <= 1'b0;
            burst_q <= 1'b0;
        end else begin
            used_q <= dec.go;
            if (dec.go) dir_q <= dec.dir;
            if (rd_gnt_o) burst_q <= !rd_last_i;
        end
    end

    // R9: back-to-back transfers keep one direction
    assert_turnaround_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_o && $past(bus_valid_o)) |-> (bus_dir_o == $past(bus_dir_o)));

    // R8, R5: a cycle carries at most one owner
    assert_one_owner_R8: assert property (@(posedge clk) disable iff (rst)
        !(map_take_o && rd_gnt_o));

    // R10: after a granted non-final word the next readout word is not blocked by a map
    assert_burst_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_gnt_o && !rd_last_i) |=> !map_take_o);

endmodule

// File: rtl/event_map_buffer.sv
module event_map_buffer #(
    parameter int DEPTH  = 4,
    parameter int MAP_W  = 32,
    parameter int HOLD_W = 6,
    parameter int CNT_W  = 16,
    parameter int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [MAP_W-1:0]  trig_map_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              busy_o,
    output logic [CNT_W-1:0]  rej_count_o,
    input  logic              seq_done_i,
    input  logic              rd_req_i,
    input  logic              rd_last_i,
    input  logic [MAP_W-1:0]  rd_data_i,
    output logic              rd_gnt_o,
    output logic              bus_valid_o,
    output logic              bus_dir_o,
    output logic [MAP_W-1:0]  bus_data_o,
    output logic [SLOT_W-1:0] bus_tag_o
);
    logic              full;
    logic              accept;
    logic              send_pending;
    logic              map_take;
    logic [MAP_W-1:0]  send_map;
    logic [SLOT_W-1:0] send_slot;

    assign busy_o = full;

    emb_holdoff_gate #(.HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig_i),
        .hold_len_i  (holdoff_i),
        .full_i      (full),
        .accept_o    (accept),
        .rej_count_o (rej_count_o)
    );

    emb_slot_fifo #(.DEPTH(DEPTH), .MAP_W(MAP_W), .SLOT_W(SLOT_W)) u_fifo (
        .clk            (clk),
        .rst            (rst),
        .wr_en_i        (accept),
        .wr_map_i       (trig_map_i),
        .send_i         (map_take),
        .retire_i       (seq_done_i),
        .full_o         (full),
        .send_pending_o (send_pending),
        .send_map_o     (send_map),
        .send_slot_o    (send_slot)
    );

    emb_bus_arbiter #(.MAP_W(MAP_W), .SLOT_W(SLOT_W)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .map_req_i   (send_pending),
        .map_i       (send_map),
        .tag_i       (send_slot),
        .rd_req_i    (rd_req_i),
        .rd_last_i   (rd_last_i),
        .rd_data_i   (rd_data_i),
        .map_take_o  (map_take),
        .rd_gnt_o    (rd_gnt_o),
        .bus_valid_o (bus_valid_o),
        .bus_dir_o   (bus_dir_o),
        .bus_data_o  (bus_data_o),
        .bus_tag_o   (bus_tag_o)
    );

    // R3: a trigger seen while busy leaves busy asserted or the count grows
    assert_busy_refuse_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && trig_i && !seq_done_i) |=> busy_o);

endmodule

// File: tb/event_map_buffer_tb_top.sv
module event_map_buffer_tb_top;
    localparam int DEPTH  = 4;
    localparam int MAP_W  = 16;
    localparam int HOLD_W = 4;
    localparam int CNT_W  = 3;
    localparam int SLOT_W = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              trig_i = 1'b0;
    logic [MAP_W-1:0]  trig_map_i = '0;
    logic [HOLD_W-1:0] holdoff_i = '0;
    logic              busy_o;
    logic [CNT_W-1:0]  rej_count_o;
    logic              seq_done_i = 1'b0;
    logic              rd_req_i = 1'b0;
    logic              rd_last_i = 1'b0;
    logic [MAP_W-1:0]  rd_data_i = '0;
    logic              rd_gnt_o;
    logic              bus_valid_o;
    logic              bus_dir_o;
    logic [MAP_W-1:0]  bus_data_o;
    logic [SLOT_W-1:0] bus_tag_o;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int nm = 0;
    int nr = 0;
    int turn_err = 0;
    logic prev_valid = 1'b0;
    logic prev_dir = 1'b0;
    logic [MAP_W-1:0] log_map [64];
    int               log_tag [64];
    int               log_cyc [64];
    bit finished = 1'b0;

    event_map_buffer #(
        .DEPTH(DEPTH), .MAP_W(MAP_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
    ) dut_i (
        .clk(clk), .rst(rst), .trig_i(trig_i), .trig_map_i(trig_map_i),
        .holdoff_i(holdoff_i), .busy_o(busy_o), .rej_count_o(rej_count_o),
        .seq_done_i(seq_done_i), .rd_req_i(rd_req_i), .rd_last_i(rd_last_i),
        .rd_data_i(rd_data_i), .rd_gnt_o(rd_gnt_o), .bus_valid_o(bus_valid_o),
        .bus_dir_o(bus_dir_o), .bus_data_o(bus_data_o), .bus_tag_o(bus_tag_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // bus monitor, samples late in the low phase
    always @(negedge clk) begin
        #8;
        if (!rst && bus_valid_o) begin
            if (bus_dir_o == 1'b0) begin
                if (nm < 64) begin
                    log_map[nm] = bus_data_o;
                    log_tag[nm] = int'(bus_tag_o);
                    log_cyc[nm] = cyc;
                end
                nm++;
            end else begin
                nr++;
            end
            if (prev_valid && (prev_dir != bus_dir_o)) turn_err++;
        end
        prev_valid = bus_valid_o && !rst;
        prev_dir   = bus_dir_o;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic [MAP_W-1:0] m, input logic d,
                        input logic rq, input logic rl, input logic [MAP_W-1:0] rdat);
        @(negedge clk);
        trig_i = t; trig_map_i = m; seq_done_i = d;
        rd_req_i = rq; rd_last_i = rl; rd_data_i = rdat;
        #8;
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        trig_i = 1'b0; seq_done_i = 1'b0; rd_req_i = 1'b0; rd_last_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        nm = 0; nr = 0; turn_err = 0;
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int t0;
        int a0;
        do_reset();
        idle();
        // R1 reset state
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "rej", int'(rej_count_o), 0);
        chk("R1", "bus_valid", int'(bus_valid_o), 0);

        // R2 sweep: holdoff H against trigger spacing g
        for (int h = 0; h <= 4; h++) begin
            for (int g = 1; g <= 6; g++) begin
                do_reset();
                holdoff_i = HOLD_W'(h);
                step(1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, '0);
                for (int k = 1; k < g; k++) idle();
                step(1'b1, 16'h0200, 1'b0, 1'b0, 1'b0, '0);
                idle();
                idle();
                chk("R2", $sformatf("rej h=%0d g=%0d", h, g), int'(rej_count_o), (g <= h) ? 1 : 0);
                chk("R2", $sformatf("maps h=%0d g=%0d", h, g), nm, (g <= h) ? 1 : 2);
            end
        end

        // R3, R5: fill past capacity with back-to-back triggers
        do_reset();
        holdoff_i = '0;
        step(1'b1, 16'hA000, 1'b0, 1'b0, 1'b0, '0);
        t0 = cyc;
        for (int k = 1; k < 6; k++) step(1'b1, 16'hA000 + 16'(k), 1'b0, 1'b0, 1'b0, '0);
        idle();
        idle();
        chk("R3", "busy when full", int'(busy_o), 1);
        chk("R4", "rej after overflow attempts", int'(rej_count_o), 2);
        chk("R5", "map count", nm, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R5", $sformatf("map %0d", k), int'(log_map[k]), 'hA000 + k);
            chk("R5", $sformatf("tag %0d", k), log_tag[k], k);
            chk("R5", $sformatf("cycle %0d", k), log_cyc[k], t0 + 1 + k);
        end

        // R6: release one slot, busy drops, next event gets slot 0
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
        idle();
        chk("R6", "busy after release", int'(busy_o), 0);
        step(1'b1, 16'hB005, 1'b0, 1'b0, 1'b0, '0);
        idle();
        idle();
        chk("R5", "fifth map", int'(log_map[4]), 'hB005);
        chk("R5", "fifth tag wraps", log_tag[4], 0);
        chk("R3", "busy refilled", int'(busy_o), 1);

        // R7: trigger with release while full is refused
        step(1'b1, 16'hC006, 1'b1, 1'b0, 1'b0, '0);
        idle();
        chk("R7", "rej when full", int'(rej_count_o), 3);
        chk("R7", "busy after release", int'(busy_o), 0);
        // R7: trigger with release at three occupied is accepted, occupancy unchanged
        step(1'b1, 16'hC007, 1'b1, 1'b0, 1'b0, '0);
        idle();
        chk("R7", "rej unchanged", int'(rej_count_o), 3);
        chk("R7", "busy stays low", int'(busy_o), 0);
        step(1'b1, 16'hC008, 1'b0, 1'b0, 1'b0, '0);
        idle();
        chk("R7", "one more fills", int'(busy_o), 1);

        // R6: release with nothing sent is ignored
        do_reset();
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
        for (int k = 0; k < 3; k++) step(1'b1, 16'hD000 + 16'(k), 1'b0, 1'b0, 1'b0, '0);
        idle();
        chk("R6", "three held not busy", int'(busy_o), 0);
        step(1'b1, 16'hD003, 1'b0, 1'b0, 1'b0, '0);
        idle();
        chk("R6", "ignored release, four fill", int'(busy_o), 1);

        // R8, R9, R10: trigger lands inside an open readout burst
        do_reset();
        idle();
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, 16'h1111);
        a0 = cyc;
        chk("R8", "first word grant", int'(rd_gnt_o), 1);
        chk("R8", "first word dir", int'(bus_dir_o), 1);
        chk("R8", "first word data", int'(bus_data_o), 'h1111);
        step(1'b1, 16'hD1D1, 1'b0, 1'b1, 1'b0, 16'h1112);
        chk("R8", "second word grant", int'(rd_gnt_o), 1);
        step(1'b0, '0, 1'b0, 1'b1, 1'b1, 16'h1113);
        chk("R10", "burst keeps bus", int'(rd_gnt_o), 1);
        chk("R10", "burst dir", int'(bus_dir_o), 1);
        idle();
        chk("R9", "gap before map", int'(bus_valid_o), 0);
        idle();
        chk("R9", "map after gap valid", int'(bus_valid_o), 1);
        chk("R9", "map after gap dir", int'(bus_dir_o), 0);
        chk("R5", "map after gap data", int'(bus_data_o), 'hD1D1);
        chk("R9", "map cycle", cyc - a0, 4);

        // R10: no burst open, map wins over a readout request
        step(1'b1, 16'hD2D2, 1'b0, 1'b0, 1'b0, '0);
        step(1'b0, '0, 1'b0, 1'b1, 1'b1, 16'h2222);
        chk("R10", "map wins, no grant", int'(rd_gnt_o), 0);
        chk("R10", "map on bus", int'(bus_data_o), 'hD2D2);
        step(1'b0, '0, 1'b0, 1'b1, 1'b1, 16'h2222);
        chk("R9", "gap before readout", int'(bus_valid_o), 0);
        step(1'b0, '0, 1'b0, 1'b1, 1'b1, 16'h2222);
        chk("R8", "readout granted", int'(rd_gnt_o), 1);
        chk("R8", "readout data", int'(bus_data_o), 'h2222);
        idle();
        chk("R8", "readout words seen", nr, 4);

        // R4: saturation of the refused count
        do_reset();
        holdoff_i = 4'd15;
        step(1'b1, 16'hE000, 1'b0, 1'b0, 1'b0, '0);
        for (int k = 0; k < 9; k++) step(1'b1, 16'hE001, 1'b0, 1'b0, 1'b0, '0);
        idle();
        chk("R4", "saturated count", int'(rej_count_o), 7);
        idle();
        chk("R4", "stable without trigger", int'(rej_count_o), 7);
        chk("R9", "turnaround violations", turn_err, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule